// File: doc/BRIEF.md
# DSP Accumulator Logical-AND Unit

This block is the logical-AND slice of a DSP data path. It keeps two 56-bit accumulators. Each one is split into an 8-bit extension (bits 55-48), a 24-bit high word (bits 47-24) and a 24-bit low word (bits 23-0). When an AND operation is issued, the unit picks one of four 24-bit source registers from a flat source bus. It ANDs that register with the high word of the chosen destination accumulator and writes the result back into that high word only. In the same clock edge it updates the condition-code flags.

In the same cycle the unit can also carry out a saturating read of either accumulator onto a 24-bit move bus. This read uses the accumulator contents from before the AND result is written back. It feeds two sticky flags: one records limiting and one records a scaling hint. Other parts of the data path use a plain write port to load the accumulators and the flag register. That port yields to an issued AND.

Top module: `dsp_and_unit`

## Requirements
- R1: On an edge with `op_valid` high, bits 47-24 of the destination accumulator (`dst_sel` 0 selects A, 1 selects B) become the AND of those bits with the source word. The source word is `src_regs[src_sel*24 +: 24]`.
- R2: An AND leaves bits 55-48 and bits 23-0 of the destination unchanged, and leaves the other accumulator entirely unchanged.
- R3: After an AND, N equals bit 47 of the new destination value. Z is 1 exactly when bits 47-24 of the new destination value are all zero, whatever the extension and low word hold.
- R4: An AND clears V and leaves C at its previous value.
- R5: When `op_valid` and `mv_en` are both high, `mv_bus` takes the accumulator chosen by `mv_sel`, as it was before the edge. The value is 24'h7FFFFF if bits 55-47 are not all equal and bit 55 is 0, 24'h800000 if they are not all equal and bit 55 is 1, and bits 47-24 otherwise. In every other cycle `mv_bus` holds its value.
- R6: When a move limits under R5, L is set. An AND never clears L, and an AND without a move leaves L unchanged.
- R7: When a move reads an accumulator whose bits 47 and 46 differ, S is set. An AND never clears S, and an AND without a move leaves S unchanged.
- R8: With `op_valid` low, `acc_wr_en` loads `acc_wr_data` into accumulator `acc_wr_sel`, and `ccr_wr_en` loads `ccr_wr_data` into the flags in bit order {L,S,N,Z,V,C} from bit 5 down to bit 0. With `op_valid` high, both load strobes are ignored.
- R9: Synchronous active-high reset clears both accumulators, all six flags and `mv_bus`.
- R10: With source 24'hFF0000 and accumulator 56'h00_123456_789ABC, an AND yields 56'h00_120000_789ABC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue an AND this cycle |
| src_sel | input | 2 | Index of the source word in `src_regs` |
| dst_sel | input | 1 | Destination accumulator, 0 = A, 1 = B |
| mv_en | input | 1 | Run a parallel saturating move with the AND |
| mv_sel | input | 1 | Accumulator read by the move, 0 = A, 1 = B |
| src_regs | input | 96 | Four 24-bit source registers, index 0 in the lowest bits |
| acc_wr_en | input | 1 | Load an accumulator |
| acc_wr_sel | input | 1 | Accumulator to load |
| acc_wr_data | input | 56 | Value to load |
| ccr_wr_en | input | 1 | Load the flag register |
| ccr_wr_data | input | 6 | Flag value, {L,S,N,Z,V,C} |
| acc_a_o | output | 56 | Accumulator A |
| acc_b_o | output | 56 | Accumulator B |
| mv_bus | output | 24 | Result of the last move |
| flag_l | output | 1 | Sticky limit flag |
| flag_s | output | 1 | Sticky scaling flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The hardest case to reach is a move that reads one accumulator while the AND rewrites that same accumulator. In that case the move must see the old value, and it must also be limiting or have differing bits 47 and 46. The sticky flags make it harder still, because they hide a missed set unless each step starts from a known flag state. The bench therefore loads both accumulators with computed patterns before every operation. Some of these patterns sit just inside and just outside the saturation range. It also presets the flags with a value that changes every step. It then sweeps every combination of source, destination, move source and move enable, so the aliased read-during-write case occurs with both flag polarities set beforehand.

// File: rtl/dsp_and_pkg.sv
package dsp_and_pkg;

    localparam int EXT_W   = 8;
    localparam int WORD_W  = 24;
    localparam int ACC_W   = EXT_W + 2 * WORD_W;
    localparam int NUM_SRC = 4;
    localparam int SEL_W   = $clog2(NUM_SRC);
    localparam int NUM_ACC = 2;

    typedef struct packed {
        logic [EXT_W-1:0]  ext;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } acc_t;

    // bit 5 down to bit 0
    typedef struct packed {
        logic l;
        logic s;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef enum logic {ACC_A = 1'b0, ACC_B = 1'b1} acc_sel_e;

    localparam logic [WORD_W-1:0] POS_MAX = {1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] NEG_MAX = {1'b1, {(WORD_W-1){1'b0}}};

    // Extension plus the high-word sign must all agree to fit in one word.
    function automatic logic needs_limit(acc_t a);
        logic [EXT_W:0] top;
        top = {a.ext, a.hi[WORD_W-1]};
        return !((&top) || !(|top));
    endfunction

    function automatic logic scale_hint(acc_t a);
        return a.hi[WORD_W-1] ^ a.hi[WORD_W-2];
    endfunction

endpackage

// File: rtl/acc_bank.sv
module acc_bank
    import dsp_and_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic                      wr_sel,
    input  acc_t                      wr_data,
    output acc_t [NUM_ACC-1:0]        acc_q
);

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q[g] <= '0;
            end else if (wr_en && (wr_sel == g[0])) begin
                acc_q[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/and_slice.sv
module and_slice
    import dsp_and_pkg::*;
(
    input  logic [WORD_W-1:0] src_word,
    input  acc_t              acc_in,
    output acc_t              acc_out,
    output logic              neg,
    output logic              zero
);

    always_comb begin
        acc_out     = acc_in;
        acc_out.hi  = acc_in.hi & src_word;
        neg         = acc_out.hi[WORD_W-1];
        zero        = (acc_out.hi == '0);
    end

endmodule

// File: rtl/move_limiter.sv
module move_limiter
    import dsp_and_pkg::*;
(
    input  acc_t              acc_in,
    output logic [WORD_W-1:0] word,
    output logic              limited,
    output logic              scaled
);

    always_comb begin
        limited = needs_limit(acc_in);
        scaled  = scale_hint(acc_in);
        if (limited) begin
            word = acc_in.ext[EXT_W-1] ? NEG_MAX : POS_MAX;
        end else begin
            word = acc_in.hi;
        end
    end

endmodule

// File: rtl/dsp_and_unit.sv
module dsp_and_unit
    import dsp_and_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       op_valid,
    input  logic [SEL_W-1:0]           src_sel,
    input  logic                       dst_sel,
    input  logic                       mv_en,
    input  logic                       mv_sel,
    input  logic [NUM_SRC*WORD_W-1:0]  src_regs,
    input  logic                       acc_wr_en,
    input  logic                       acc_wr_sel,
    input  logic [ACC_W-1:0]           acc_wr_data,
    input  logic                       ccr_wr_en,
    input  logic [5:0]                 ccr_wr_data,
    output logic [ACC_W-1:0]           acc_a_o,
    output logic [ACC_W-1:0]           acc_b_o,
    output logic [WORD_W-1:0]          mv_bus,
    output logic                       flag_l,
    output logic                       flag_s,
    output logic                       flag_n,
    output logic                       flag_z,
    output logic                       flag_v,
    output logic                       flag_c
);

    acc_t [NUM_ACC-1:0] acc_q;
    acc_t               dst_cur;
    acc_t               dst_new;
    acc_t               mv_src;
    acc_t               bank_wdata;
    logic               bank_wen;
    logic               bank_wsel;
    logic [WORD_W-1:0]  src_word;
    logic [WORD_W-1:0]  mv_word;
    logic               res_neg;
    logic               res_zero;
    logic               mv_lim;
    logic               mv_scl;
    ccr_t               ccr_q;

    assign src_word = src_regs[src_sel*WORD_W +: WORD_W];
    assign dst_cur  = acc_q[dst_sel];
    assign mv_src   = acc_q[mv_sel];

    and_slice u_and (
        .src_word (src_word),
        .acc_in   (dst_cur),
        .acc_out  (dst_new),
        .neg      (res_neg),
        .zero     (res_zero)
    );

    move_limiter u_move (
        .acc_in  (mv_src),
        .word    (mv_word),
        .limited (mv_lim),
        .scaled  (mv_scl)
    );

    // An issued operation owns the write port.
    always_comb begin
        bank_wen   = op_valid || acc_wr_en;
        bank_wsel  = op_valid ? dst_sel : acc_wr_sel;
        bank_wdata = op_valid ? dst_new : acc_t'(acc_wr_data);
    end

    acc_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bank_wen),
        .wr_sel  (bank_wsel),
        .wr_data (bank_wdata),
        .acc_q   (acc_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ccr_q <= '0;
        end else if (op_valid) begin
            ccr_q.n <= res_neg;
            ccr_q.z <= res_zero;
            ccr_q.v <= 1'b0;
            if (mv_en) begin
                ccr_q.l <= ccr_q.l | mv_lim;
                ccr_q.s <= ccr_q.s | mv_scl;
            end
        end else if (ccr_wr_en) begin
            ccr_q <= ccr_t'(ccr_wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mv_bus <= '0;
        end else if (op_valid && mv_en) begin
            mv_bus <= mv_word;
        end
    end

    assign acc_a_o = acc_q[ACC_A];
    assign acc_b_o = acc_q[ACC_B];
    assign flag_l  = ccr_q.l;
    assign flag_s  = ccr_q.s;
    assign flag_n  = ccr_q.n;
    assign flag_z  = ccr_q.z;
    assign flag_v  = ccr_q.v;
    assign flag_c  = ccr_q.c;

    assert_v_cleared_R4: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> !flag_v);

    assert_c_kept_R4: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> flag_c == $past(flag_c));

    assert_l_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && flag_l) |=> flag_l);

    assert_s_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && flag_s) |=> flag_s);

    assert_ext_low_kept_a_R2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !dst_sel) |=>
            (acc_a_o[ACC_W-1:2*WORD_W] == $past(acc_a_o[ACC_W-1:2*WORD_W]))
         && (acc_a_o[WORD_W-1:0] == $past(acc_a_o[WORD_W-1:0]))
         && $stable(acc_b_o));

    assert_ext_low_kept_b_R2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && dst_sel) |=>
            (acc_b_o[ACC_W-1:2*WORD_W] == $past(acc_b_o[ACC_W-1:2*WORD_W]))
         && (acc_b_o[WORD_W-1:0] == $past(acc_b_o[WORD_W-1:0]))
         && $stable(acc_a_o));

    assert_bus_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(op_valid && mv_en) |=> $stable(mv_bus));

    assert_bus_saturates_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && mv_en && !mv_sel && needs_limit(acc_t'(acc_a_o))) |=>
            (mv_bus == POS_MAX || mv_bus == NEG_MAX) && flag_l);

endmodule

// File: tb/test_dsp_and_unit.sv
module test_dsp_and_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid, dst_sel, mv_en, mv_sel;
    logic [1:0]  src_sel;
    logic [95:0] src_regs;
    logic        acc_wr_en, acc_wr_sel, ccr_wr_en;
    logic [55:0] acc_wr_data;
    logic [5:0]  ccr_wr_data;
    logic [55:0] acc_a_o, acc_b_o;
    logic [23:0] mv_bus;
    logic        flag_l, flag_s, flag_n, flag_z, flag_v, flag_c;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    dsp_and_unit i_dsp_and_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .src_sel(src_sel),
        .dst_sel(dst_sel), .mv_en(mv_en), .mv_sel(mv_sel), .src_regs(src_regs),
        .acc_wr_en(acc_wr_en), .acc_wr_sel(acc_wr_sel), .acc_wr_data(acc_wr_data),
        .ccr_wr_en(ccr_wr_en), .ccr_wr_data(ccr_wr_data),
        .acc_a_o(acc_a_o), .acc_b_o(acc_b_o), .mv_bus(mv_bus),
        .flag_l(flag_l), .flag_s(flag_s), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] flags();
        return {flag_l, flag_s, flag_n, flag_z, flag_v, flag_c};
    endfunction

    function automatic logic [55:0] pat(input int k);
        case (k % 8)
            0: return 56'h00_7FFFFF_000001;
            1: return 56'hFF_800000_FFFFFF;
            2: return 56'h01_234567_89ABCD;
            3: return 56'hFE_C00000_123456;
            4: return 56'h00_400000_ABCDEF;
            5: return 56'hFF_BFFFFF_000000;
            6: return 56'h00_FFFFFF_555555;
            default: return {k[7:0] * 8'h3B, 24'(k * 32'h9E3779), 24'(k * 32'h7F4A7C)};
        endcase
    endfunction

    task automatic idle();
        op_valid = 0; acc_wr_en = 0; ccr_wr_en = 0; mv_en = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic load_acc(input logic sel, input logic [55:0] v);
        acc_wr_en = 1; acc_wr_sel = sel; acc_wr_data = v;
        step();
    endtask

    // bench model of one operation, computed from the requirements
    logic [55:0] ea, eb;
    logic [23:0] emv;
    logic [5:0]  ef;

    task automatic model(input logic [1:0] s, input logic d, input logic me, input logic ms);
        logic [55:0] dcur, mcur;
        logic [23:0] w, r;
        logic [8:0]  top;
        logic        lim;
        dcur = d ? eb : ea;
        mcur = ms ? eb : ea;
        w = src_regs[s*24 +: 24];
        r = dcur[47:24] & w;
        dcur[47:24] = r;
        top = mcur[55:47];
        lim = (top != 9'h000) && (top != 9'h1FF);
        if (me) begin
            emv = lim ? (mcur[55] ? 24'h800000 : 24'h7FFFFF) : mcur[47:24];
            ef[5] = ef[5] | lim;
            ef[4] = ef[4] | (mcur[47] != mcur[46]);
        end
        ef[3] = r[23];
        ef[2] = (r == 24'h0);
        ef[1] = 1'b0;
        if (d) eb = dcur; else ea = dcur;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle();
        src_sel = 0; dst_sel = 0; mv_sel = 0; src_regs = '0;
        acc_wr_sel = 0; acc_wr_data = '0; ccr_wr_data = '0;
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;

        // R9 reset state
        chk("R9 acc A", 64'(acc_a_o), 64'h0);
        chk("R9 acc B", 64'(acc_b_o), 64'h0);
        chk("R9 flags", 64'(flags()), 64'h0);
        chk("R9 mv_bus", 64'(mv_bus), 64'h0);

        // R10 worked example
        src_regs = {72'h0, 24'hFF0000};
        load_acc(0, 56'h00_123456_789ABC);
        op_valid = 1; src_sel = 0; dst_sel = 0;
        step();
        chk("R10 example result", 64'(acc_a_o), 64'h00_120000_789ABC);
        chk("R3 N example", 64'(flag_n), 64'h0);
        chk("R3 Z example", 64'(flag_z), 64'h0);

        // R8 load strobes ignored while an operation is issued
        load_acc(1, 56'hAA_0F0F0F_333333);
        ccr_wr_en = 1; ccr_wr_data = 6'b000011;
        step();
        src_regs = {24'h0, 24'h0, 24'hF00000, 24'h0};
        op_valid = 1; src_sel = 1; dst_sel = 1; mv_en = 0;
        acc_wr_en = 1; acc_wr_sel = 1; acc_wr_data = 56'h11_111111_111111;
        ccr_wr_en = 1; ccr_wr_data = 6'b110000;
        step();
        chk("R8 acc load ignored", 64'(acc_b_o), 64'hAA_000000_333333);
        chk("R8 ccr load ignored, R3 Z and R4 C", 64'(flags()), 64'b000101);

        // R8 ccr load order when idle
        ccr_wr_en = 1; ccr_wr_data = 6'b101010;
        step();
        chk("R8 ccr load order", 64'(flags()), 64'b101010);

        // R5 bus holds without a move
        load_acc(0, 56'h00_7FFFFF_000000);
        op_valid = 1; mv_en = 1; mv_sel = 0; dst_sel = 1; src_sel = 0;
        step();
        chk("R5 move value", 64'(mv_bus), 64'h7FFFFF);
        op_valid = 1; mv_en = 0; src_sel = 3;
        step();
        chk("R5 bus holds", 64'(mv_bus), 64'h7FFFFF);
        load_acc(0, 56'h05_000000_000000);
        chk("R5 bus holds on load", 64'(mv_bus), 64'h7FFFFF);

        // sweep: R1 R2 R3 R4 R5 R6 R7
        for (int k = 0; k < 12; k++) begin
            for (int s = 0; s < 4; s++) begin
                for (int d = 0; d < 2; d++) begin
                    for (int ms = 0; ms < 2; ms++) begin
                        for (int me = 0; me < 2; me++) begin
                            ea = pat(k);
                            eb = pat(k + 3 + s);
                            src_regs = {24'(k * 32'h1F3D5B) | 24'h800000, 24'hFFFFFF,
                                        24'(k * 32'hC0FFEE), 24'h0F0F0F ^ 24'(k << 20)};
                            load_acc(0, ea);
                            load_acc(1, eb);
                            ef = 6'((k * 11 + s * 5 + d * 3 + ms + me * 7) % 64);
                            ccr_wr_en = 1; ccr_wr_data = ef;
                            step();
                            emv = mv_bus;
                            model(2'(s), d[0], me[0], ms[0]);
                            op_valid = 1; src_sel = 2'(s); dst_sel = d[0];
                            mv_en = me[0]; mv_sel = ms[0];
                            step();
                            chk("R1 R2 acc A", 64'(acc_a_o), 64'(ea));
                            chk("R1 R2 acc B", 64'(acc_b_o), 64'(eb));
                            chk("R5 mv_bus", 64'(mv_bus), 64'(emv));
                            chk("R3 R4 R6 R7 flags", 64'(flags()), 64'(ef));
                        end
                    end
                end
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule